// File: doc/BRIEF.md
# Branch Trace Buffer with Loop Compression

This block keeps a circular history of program-flow discontinuities. Each recorded event is a pair of 32-bit addresses: the address that branched (source) and the address it went to (destination). A capture port presents one candidate event per cycle together with a flag that marks hardware-loop iterations and the interrupt level the core is running at. Gating rules decide whether the event is recorded. Two optional compression modes fold tight repeating loops into one or two entries by setting bit 0 of an existing address instead of storing a new pair.

Software reaches the block through a simple 32-bit register port with a select, a write flag, a 12-bit byte offset and write and read data. The read data is combinational for the cycle in which the port is selected. Three locations are decoded: a control word, an entry count, and a data location that pops entries newest first. Each entry is delivered in two reads. When the store is full, the block either discards the oldest entry or, if configured to do so, drops the new event and pulses an overflow exception line. The depth is a parameter and must be a power of two.

Top module: `brtrace_buf`

## Requirements
- R1: Offset 0x000 holds the control word. It is read/write, and only bits 4:0 are kept: bit 0 enable, bit 1 power, bit 2 overflow-exception, bit 3 one-level compression, bit 4 two-level compression. Upper bits read as 0. Writes to offset 0x004 or 0x100 change nothing, and reads of any undecoded offset return 0.
- R2: An event is recorded only while both the enable bit and the power bit are 1.
- R3: An event with the hardware-loop flag set is never recorded, and neither is an event at interrupt level 1 (reset level).
- R4: While the overflow-exception bit is 1, events at interrupt levels 0 through 3 are not recorded.
- R5: When the store holds DEPTH entries and the overflow-exception bit is 1, a gated-in event is dropped. ovf_exc is then high for exactly the one cycle after the capture edge.
- R6: When the store holds DEPTH entries and the overflow-exception bit is 0, an appended event replaces the oldest entry. All other entries are kept and the count stays at DEPTH.
- R7: With one-level compression on and at least one entry stored, an event whose source and destination equal the newest entry's (bit 0 ignored on both sides) is not stored. Bit 0 of that entry's destination is set instead.
- R8: With two-level compression on and at least two entries stored, an event that matches the second-newest entry (bit 0 ignored) is not stored. Bit 0 of that entry's source is set instead. A one-level match takes priority over a two-level match.
- R9: A read of offset 0x100 with no entries stored returns 0 and changes no state.
- R10: Reads of offset 0x100 alternate. The first returns the newest entry's destination, and the next returns its source and removes that entry.
- R11: A read of offset 0x004 returns the number of stored entries, saturated at 16.
- R12: A capture presented in the same cycle as a read of offset 0x100 is not recorded.
- R13: Reset clears the control word, empties the store and restarts the two-read alternation at the destination half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Capture event strobe |
| cap_src | input | 32 | Source address of the discontinuity |
| cap_dst | input | 32 | Destination address of the discontinuity |
| cap_loop | input | 1 | Event is a hardware-loop iteration |
| cap_level | input | 4 | Current interrupt level |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ovf_exc | output | 1 | Overflow exception pulse |

## Verification
The bench sweeps all sixteen interrupt levels under both settings of the overflow-exception bit. A design with an off-by-one level compare would record a level-3 event, or lose level 4. It overfills the store in both overflow modes. A pointer bug there would show as a lost newest entry, a wrong oldest survivor, or an exception that fires while entries are still being overwritten. The compression cases repeat pairs that differ only in bit 0 and put the second-newest match behind a newest match. That catches a design that compares full addresses, marks the wrong half, or lets the two-level check win. It also collides a capture with a pop, and reads the empty store in the middle of a run, so a stray toggle of the half-read state would return a source where a destination is due.

// File: rtl/brtrace_buf.sv
module brtrace_buf #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_valid,
  input  logic [31:0] cap_src,
  input  logic [31:0] cap_dst,
  input  logic        cap_loop,
  input  logic [3:0]  cap_level,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        ovf_exc
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [11:0] OFS_CTRL = 12'h000;
  localparam logic [11:0] OFS_STAT = 12'h004;
  localparam logic [11:0] OFS_DATA = 12'h100;
  localparam logic [3:0]  LVL_RST  = 4'd1;
  localparam logic [3:0]  LVL_HIGH = 4'd3;

  logic [4:0]  ctrl;
  logic [AW:0] top_ptr, bot_ptr;
  logic        mid;
  logic        ovf_q;
  logic [31:0] src_mem [DEPTH];
  logic [31:0] dst_mem [DEPTH];

  logic [AW:0]   cnt;
  logic [AW-1:0] top_i, last_i, prev_i;
  logic          full, rd_data, wr_ctrl, lvl_ok, take, exc_now;
  logic          hit1, hit2, append;
  logic          unused_wdata;

  assign cnt    = top_ptr - bot_ptr;
  assign full   = cnt == (AW+1)'(DEPTH);
  assign top_i  = AW'(top_ptr);
  assign last_i = AW'(top_ptr - 1'b1);
  assign prev_i = AW'(top_ptr - 2'd2);

  assign rd_data = bus_sel && !bus_wr && bus_addr == OFS_DATA;
  assign wr_ctrl = bus_sel && bus_wr && bus_addr == OFS_CTRL;
  assign unused_wdata = ^bus_wdata[31:5];

  assign lvl_ok  = cap_level != LVL_RST && !(ctrl[2] && cap_level <= LVL_HIGH);
  assign take    = cap_valid && ctrl[0] && ctrl[1] && !cap_loop && lvl_ok && !rd_data;
  assign exc_now = take && full && ctrl[2];

  assign hit1 = ctrl[3] && cnt != '0
             && cap_src[31:1] == src_mem[last_i][31:1]
             && cap_dst[31:1] == dst_mem[last_i][31:1];
  assign hit2 = ctrl[4] && cnt >= (AW+1)'(2)
             && cap_src[31:1] == src_mem[prev_i][31:1]
             && cap_dst[31:1] == dst_mem[prev_i][31:1];
  assign append = take && !exc_now && !hit1 && !hit2;

  always_ff @(posedge clk) begin
    if (append) begin
      src_mem[top_i] <= cap_src;
      dst_mem[top_i] <= cap_dst;
    end else if (take && !exc_now && hit1) begin
      dst_mem[last_i][0] <= 1'b1;
    end else if (take && !exc_now && hit2) begin
      src_mem[prev_i][0] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      top_ptr <= '0;
      bot_ptr <= '0;
      mid     <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= exc_now;
      if (wr_ctrl) ctrl <= bus_wdata[4:0];
      if (append) begin
        top_ptr <= top_ptr + 1'b1;
        if (full) bot_ptr <= bot_ptr + 1'b1;
      end else if (rd_data && cnt != '0) begin
        mid <= !mid;
        if (mid) top_ptr <= top_ptr - 1'b1;
      end
    end
  end

  assign ovf_exc = ovf_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata = {27'b0, ctrl};
        OFS_STAT: bus_rdata = (32'(cnt) > 32'd16) ? 32'd16 : 32'(cnt);
        OFS_DATA: if (cnt != '0) bus_rdata = mid ? src_mem[last_i] : dst_mem[last_i];
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/brtrace_buf_chk.sv
module brtrace_buf_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic        cap_valid,
  input logic        cap_loop,
  input logic [4:0]  ctrl,
  input logic [AW:0] cnt,
  input logic        mid,
  input logic        ovf_exc
);
  logic rd_stat, rd_data;
  assign rd_stat = bus_sel && !bus_wr && bus_addr == 12'h004;
  assign rd_data = bus_sel && !bus_wr && bus_addr == 12'h100;

  AST_STAT_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> bus_rdata <= 32'd16); // R11
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && cnt == '0 |-> bus_rdata == 32'd0); // R9
  AST_EMPTY_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && cnt == '0 |=> cnt == '0 && mid == $past(mid)); // R9
  AST_SECOND_HALF_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && cnt != '0 && mid |=> cnt == $past(cnt) - 1'b1 && !mid); // R10
  AST_OFF_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl[0] && ctrl[1]) |=> cnt <= $past(cnt)); // R2
  AST_LOOP_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && cap_loop |=> cnt <= $past(cnt)); // R3
  AST_POP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && cap_valid |=> cnt <= $past(cnt)); // R12
  AST_EXC_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_exc |-> 32'($past(cnt)) == DEPTH && $past(ctrl[2])); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= DEPTH); // R6
endmodule

bind brtrace_buf brtrace_buf_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .cap_valid(cap_valid),
  .cap_loop(cap_loop), .ctrl(ctrl), .cnt(cnt), .mid(mid), .ovf_exc(ovf_exc)
);

// File: tb/brtrace_buf_tb_top.sv
module brtrace_buf_tb_top;
  localparam int D = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0, cap_loop = 1'b0;
  logic [31:0] cap_src = '0, cap_dst = '0;
  logic [3:0]  cap_level = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ovf_exc;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [31:0] qs[$];
  logic [31:0] qd[$];
  logic        mmid = 1'b0;
  logic [4:0]  mctrl = '0;
  logic        mexc = 1'b0;

  always #5 clk = ~clk;

  brtrace_buf #(.DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_src(cap_src),
    .cap_dst(cap_dst), .cap_loop(cap_loop), .cap_level(cap_level),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_exc(ovf_exc)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_pop_read(output logic [31:0] e);
    if (qs.size() == 0) e = 0;
    else begin
      e = mmid ? qs[$] : qd[$];
      if (mmid) begin void'(qs.pop_back()); void'(qd.pop_back()); end
      mmid = !mmid;
    end
  endtask

  function automatic bit same(logic [31:0] a, logic [31:0] b);
    return a[31:1] == b[31:1];
  endfunction

  task automatic model_cap(logic [31:0] s, logic [31:0] d, logic lp, logic [3:0] lv);
    int n;
    bit isfull;
    mexc = 0;
    n = qs.size();
    if (!(mctrl[0] && mctrl[1]) || lp || lv == 4'd1) return;
    if (mctrl[2] && lv <= 4'd3) return;
    isfull = (n == D);
    if (isfull && mctrl[2]) begin mexc = 1; return; end
    if (mctrl[3] && n >= 1 && same(s, qs[n-1]) && same(d, qd[n-1])) begin
      qd[n-1][0] = 1'b1; return;
    end
    if (mctrl[4] && n >= 2 && same(s, qs[n-2]) && same(d, qd[n-2])) begin
      qs[n-2][0] = 1'b1; return;
    end
    if (isfull) begin void'(qs.pop_front()); void'(qd.pop_front()); end
    qs.push_back(s);
    qd.push_back(d);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a == 12'h000) mctrl = v[4:0];
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    logic [31:0] dummy;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
    if (a == 12'h100) model_pop_read(dummy);
  endtask

  task automatic cap(logic [31:0] s, logic [31:0] d, logic lp, logic [3:0] lv, string req);
    @(negedge clk);
    cap_valid = 1; cap_src = s; cap_dst = d; cap_loop = lp; cap_level = lv;
    @(negedge clk);
    cap_valid = 0; cap_loop = 0;
    model_cap(s, d, lp, lv);
    #1 chk({req, " exception pulse"}, {31'b0, ovf_exc}, {31'b0, mexc});
  endtask

  task automatic chk_stat(string req);
    logic [31:0] v;
    int n;
    n = qs.size();
    rd(12'h004, v);
    chk({req, " status"}, v, (n > 16) ? 32'd16 : 32'(n));
  endtask

  task automatic drain(string req);
    logic [31:0] v, e;
    while (qs.size() > 0) begin
      e = mmid ? qs[$] : qd[$];
      rd(12'h100, v);
      chk({req, " pop data"}, v, e);
    end
    rd(12'h100, v);
    chk({req, " empty read"}, v, 32'd0);
    chk_stat(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R13 reset state
    rd(12'h000, v); chk("R13 ctrl after reset", v, 0);
    chk_stat("R13");
    rd(12'h100, v); chk("R13 R9 data after reset", v, 0);

    // R1 decode
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R1 ctrl readback", v, 32'h1F);
    wr(12'h000, 32'h0000_0003);
    wr(12'h004, 32'h0000_0007);
    wr(12'h100, 32'h1234_5678);
    rd(12'h000, v); chk("R1 ctrl after ro writes", v, 32'h3);
    chk_stat("R1");
    rd(12'h100, v); chk("R1 data after ro write", v, 0);
    rd(12'h008, v); chk("R1 undecoded read", v, 0);

    // R2 sweep of enable/power
    for (int c = 0; c < 4; c++) begin
      wr(12'h000, 32'(c));
      cap(32'h0000_4000 + 32'(c*16), 32'h0000_8000 + 32'(c*16), 0, 4'd6, "R2");
      chk_stat("R2");
    end
    drain("R2");

    // R3 R4 level sweep, both overflow-exception settings
    for (int x = 0; x < 2; x++) begin
      wr(12'h000, x ? 32'h7 : 32'h3);
      for (int lv = 0; lv < 16; lv++) begin
        cap(32'h0001_0000 + 32'(lv*8 + x*256), 32'h0002_0000 + 32'(lv*8), 0, 4'(lv), "R3 R4");
        chk_stat(x ? "R4 level" : "R3 level");
      end
      cap(32'h0003_0000, 32'h0004_0000, 1, 4'd7, "R3 loop");
      chk_stat("R3 loop");
      drain("R3 R4");
    end

    // R6 overwrite oldest, R11 saturation
    wr(12'h000, 32'h3);
    for (int i = 0; i < D + 3; i++) begin
      cap(32'h0010_0000 + 32'(i*4), 32'h0020_0000 + 32'(i*4), 0, 4'd8, "R6");
      if (i == 15 || i == 16 || i == D + 2) chk_stat("R6 R11");
    end
    drain("R6");

    // R5 exception on full
    wr(12'h000, 32'h7);
    for (int i = 0; i < D + 2; i++)
      cap(32'h0030_0000 + 32'(i*4), 32'h0040_0000 + 32'(i*4), 0, 4'd9, "R5");
    chk_stat("R5");
    drain("R5");

    // R7 one-level compression, bit 0 of input ignored
    wr(12'h000, 32'hB);
    cap(32'h0000_1000, 32'h0000_2000, 0, 4'd6, "R7");
    cap(32'h0000_1000, 32'h0000_2000, 0, 4'd6, "R7");
    cap(32'h0000_1001, 32'h0000_2001, 0, 4'd6, "R7");
    chk_stat("R7");
    drain("R7");

    // R8 two-level compression
    wr(12'h000, 32'h13);
    cap(32'h0000_1100, 32'h0000_2100, 0, 4'd6, "R8");
    cap(32'h0000_1200, 32'h0000_2200, 0, 4'd6, "R8");
    cap(32'h0000_1100, 32'h0000_2100, 0, 4'd6, "R8");
    chk_stat("R8");
    drain("R8");

    // R8 priority: newest and second-newest both match
    cap(32'h0000_1300, 32'h0000_2300, 0, 4'd6, "R8");
    cap(32'h0000_1300, 32'h0000_2300, 0, 4'd6, "R8");
    wr(12'h000, 32'h1B);
    cap(32'h0000_1300, 32'h0000_2300, 0, 4'd6, "R8 priority");
    chk_stat("R8 priority");
    drain("R8 priority");

    // R12 capture colliding with a pop
    wr(12'h000, 32'h3);
    cap(32'h0000_5000, 32'h0000_6000, 0, 4'd6, "R12");
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 12'h100;
    cap_valid = 1; cap_src = 32'h0000_7000; cap_dst = 32'h0000_7100; cap_level = 4'd6;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 0; cap_valid = 0;
    begin logic [31:0] e; model_pop_read(e); chk("R12 R10 read during capture", v, e); end
    chk_stat("R12");
    drain("R12");

    // R9 empty read then fresh entry starts at destination
    rd(12'h100, v); chk("R9 empty", v, 0);
    cap(32'h0000_8800, 32'h0000_9900, 0, 4'd6, "R9");
    rd(12'h100, v); chk("R9 R10 first half", v, 32'h0000_9900);
    rd(12'h100, v); chk("R10 second half", v, 32'h0000_8800);
    chk_stat("R10");

    // R13 reset mid-run
    cap(32'h0000_A000, 32'h0000_B000, 0, 4'd6, "R13");
    rd(12'h100, v);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    qs.delete(); qd.delete(); mmid = 0; mctrl = 0;
    rd(12'h000, v); chk("R13 ctrl cleared", v, 0);
    chk_stat("R13");
    wr(12'h000, 32'h3);
    cap(32'h0000_C000, 32'h0000_D000, 0, 4'd6, "R13");
    rd(12'h100, v); chk("R13 half-read restarts", v, 32'h0000_D000);
    drain("R13");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule